// File: doc/BRIEF.md
# Lens-Bus Host Byte Engine

This block is the body-side controller for a three-wire synchronous lens link: a shared clock line, a data line toward the lens and a data line back from the lens. It moves one byte in each direction at a time, most significant bit first. The clock idles high, the outgoing bit changes while the clock is low, and the returning bit is sampled when the clock rises. No select or framing line exists. The controller counts bytes purely by clock edges.

After the eighth rising edge the host keeps driving the clock high for a short hold time. It then lets go of the clock line and waits for the lens to pull it low and later release it. This low pulse is the lens's acknowledge and busy indication, and it may last anywhere from a few microseconds to several milliseconds. When the line returns high, the received byte is presented with a one-cycle done strobe. The host then holds off the next byte for a minimum gap. A missing acknowledge or an over-long busy pulse raises a one-cycle error strobe and returns the engine to idle.

Two host speeds exist: a slow rate of 13 µs per bit and a fast rate of 2 µs per bit. Each speed has its own minimum gap, 120 µs and 18 µs. The lens-side waits are the same at both speeds. Every duration is given in nanoseconds and converted to system clock cycles from the clock frequency parameter, rounded up.

Top module: `lensbus_host`

## Requirements
- R1: After reset the clock line is not driven (`lclk_oe_o`=0), `dout_o` is 1, and `done_o` and `err_o` are 0.
- R2: A `start_i` accepted in idle drives the clock low on the next cycle. The engine then produces exactly 8 falling and 8 rising clock edges. During the low phase of the n-th bit (n=1..8), `dout_o` equals `tx_byte_i` bit 8−n, so bit 7 goes first, and it stays unchanged through that bit's high phase.
- R3: With `done_o`, `rx_byte_o` holds the 8 `din_i` values sampled at the 8 rising edges, the first one in bit 7.
- R4: Each low phase, and each high phase between bits, lasts ceil(HALF_NS·CLK_HZ/1e9) cycles, where HALF_NS is SLOW_HALF_NS with `fast_mode_i`=0 and FAST_HALF_NS with `fast_mode_i`=1.
- R5: After the eighth rising edge the clock stays driven high for ceil(RELEASE_NS·CLK_HZ/1e9) cycles. The host then releases the clock line and `dout_o` goes to 1.
- R6: While the lens holds the clock low, for any length up to the busy limit, `done_o` stays 0. `done_o` rises SYNC_STAGES+1 cycles after the line returns high and lasts exactly one cycle.
- R7: A new `start_i` is accepted only when at least ceil(GAP_NS·CLK_HZ/1e9) cycles have passed since the `done_o` cycle, using GAP_SLOW_NS or GAP_FAST_NS for the byte's mode. An earlier `start_i` is dropped and does not drive the clock. A `start_i` exactly at the limit is taken.
- R8: If the line is not seen low within ceil(ACK_TMO_NS·CLK_HZ/1e9) cycles of the release, `err_o` pulses for one cycle at that count, `done_o` is not raised, and the engine returns to idle.
- R9: If the line stays low longer than ceil(BUSY_TMO_NS·CLK_HZ/1e9) cycles after the low is detected, `err_o` pulses for one cycle, `done_o` is not raised, and the engine returns to idle.
- R10: The speed mode and the outgoing byte are captured with `start_i`. During a byte in progress, changes on `fast_mode_i`, `tx_byte_i` and `start_i` have no effect on the timing or on `dout_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_mode_i | input | 1 | 1 selects the fast bit rate, captured with start |
| start_i | input | 1 | Begin one byte exchange (taken in idle only) |
| tx_byte_i | input | 8 | Byte to send, captured with start |
| rx_byte_o | output | 8 | Received byte, valid with done_o |
| done_o | output | 1 | One-cycle strobe at the end of a good exchange |
| err_o | output | 1 | One-cycle strobe on acknowledge or busy timeout |
| lclk_o | output | 1 | Value driven onto the shared clock line |
| lclk_oe_o | output | 1 | 1 while the host drives the clock line |
| lclk_i | input | 1 | Observed level of the shared clock line |
| dout_o | output | 1 | Host-to-lens data |
| din_i | input | 1 | Lens-to-host data |

## Verification
The bench builds the engine with a 2 MHz system clock, a 20 µs acknowledge limit and a 200 µs busy limit. These settings give a 13-cycle slow half bit, a 2-cycle fast half bit, a 2-cycle hold, gaps of 240 and 36 cycles, and timeouts of 40 and 400 cycles. With them every outgoing byte value can be swept in fast mode, a set of slow-mode bytes can be run, and the exact cycle edges of both timeouts, the latest acknowledge and the longest busy pulse can be reached within a short run. Expected counts come from the same ceiling formula, evaluated in the bench.

// File: rtl/lensbus_pkg.sv
package lensbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_WACK,
        ST_BUSY,
        ST_GAP
    } lb_state_e;

    typedef struct packed {
        lb_state_e  st;
        logic       fast;
        logic [2:0] bitn;
        logic       done;
        logic       err;
    } lb_ctl_t;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic longint unsigned ns_to_cyc(input longint unsigned clk_hz,
                                                  input longint unsigned ns);
        longint unsigned c;
        c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lensbus_sync.sv
module lensbus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    // line idles high, so reset to the idle level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lensbus_timer.sv
module lensbus_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = load_val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lensbus_shift.sv
module lensbus_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] load_byte_i,
    input  logic       tx_adv_i,
    input  logic       rx_cap_i,
    input  logic       rx_bit_i,
    output logic       tx_msb_o,
    output logic [7:0] rx_byte_o
);
    logic [7:0] tx_d, tx_q;
    logic [7:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load_i)        tx_d = load_byte_i;
        else if (tx_adv_i) tx_d = {tx_q[6:0], 1'b1};
        if (rx_cap_i)      rx_d = {rx_q[6:0], rx_bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '1;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_msb_o  = tx_q[7];
    assign rx_byte_o = rx_q;
endmodule

// File: rtl/lensbus_host.sv
module lensbus_host #(
    parameter longint unsigned CLK_HZ       = 64'd50_000_000,
    parameter longint unsigned SLOW_HALF_NS = 64'd6_500,
    parameter longint unsigned FAST_HALF_NS = 64'd1_000,
    parameter longint unsigned RELEASE_NS   = 64'd1_000,
    parameter longint unsigned GAP_SLOW_NS  = 64'd120_000,
    parameter longint unsigned GAP_FAST_NS  = 64'd18_000,
    parameter longint unsigned ACK_TMO_NS   = 64'd100_000,
    parameter longint unsigned BUSY_TMO_NS  = 64'd10_000_000,
    parameter int unsigned     SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fast_mode_i,
    input  logic       start_i,
    input  logic [7:0] tx_byte_i,
    output logic [7:0] rx_byte_o,
    output logic       done_o,
    output logic       err_o,
    output logic       lclk_o,
    output logic       lclk_oe_o,
    input  logic       lclk_i,
    output logic       dout_o,
    input  logic       din_i
);
    import lensbus_pkg::*;

    localparam int unsigned SLOW_HALF = 32'(ns_to_cyc(CLK_HZ, SLOW_HALF_NS));
    localparam int unsigned FAST_HALF = 32'(ns_to_cyc(CLK_HZ, FAST_HALF_NS));
    localparam int unsigned HOLD_CYC  = 32'(ns_to_cyc(CLK_HZ, RELEASE_NS));
    localparam int unsigned GAP_SLOW  = 32'(ns_to_cyc(CLK_HZ, GAP_SLOW_NS));
    localparam int unsigned GAP_FAST  = 32'(ns_to_cyc(CLK_HZ, GAP_FAST_NS));
    localparam int unsigned ACK_CYC   = 32'(ns_to_cyc(CLK_HZ, ACK_TMO_NS));
    localparam int unsigned BUSY_CYC  = 32'(ns_to_cyc(CLK_HZ, BUSY_TMO_NS));
    localparam int unsigned MAX_CYC   = umax(umax(umax(SLOW_HALF, FAST_HALF), umax(HOLD_CYC, GAP_SLOW)),
                                             umax(umax(GAP_FAST, ACK_CYC), BUSY_CYC));
    localparam int unsigned TW        = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] LD_SLOW_HALF = TW'(SLOW_HALF - 1);
    localparam logic [TW-1:0] LD_FAST_HALF = TW'(FAST_HALF - 1);
    localparam logic [TW-1:0] LD_HOLD      = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] LD_GAP_SLOW  = TW'(GAP_SLOW - 1);
    localparam logic [TW-1:0] LD_GAP_FAST  = TW'(GAP_FAST - 1);
    localparam logic [TW-1:0] LD_ACK       = TW'(ACK_CYC - 1);
    localparam logic [TW-1:0] LD_BUSY      = TW'(BUSY_CYC - 1);

    lb_ctl_t ctl_d, ctl_q;

    logic          lclk_s;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sh_load, tx_adv, rx_cap, tx_msb;

    lensbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lclk_i),
        .sync_o  (lclk_s)
    );

    lensbus_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    lensbus_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load),
        .load_byte_i (tx_byte_i),
        .tx_adv_i    (tx_adv),
        .rx_cap_i    (rx_cap),
        .rx_bit_i    (din_i),
        .tx_msb_o    (tx_msb),
        .rx_byte_o   (rx_byte_o)
    );

    // next-state computation
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_load    = 1'b0;
        tx_adv     = 1'b0;
        rx_cap     = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_LOW;
                    ctl_d.fast = fast_mode_i;
                    ctl_d.bitn = '0;
                    sh_load    = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = fast_mode_i ? LD_FAST_HALF : LD_SLOW_HALF;
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    rx_cap   = 1'b1;
                    tmr_load = 1'b1;
                    if (ctl_q.bitn == 3'd7) begin
                        ctl_d.st = ST_HOLD;
                        tmr_val  = LD_HOLD;
                    end else begin
                        ctl_d.st = ST_HIGH;
                        tmr_val  = ctl_q.fast ? LD_FAST_HALF : LD_SLOW_HALF;
                    end
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_LOW;
                    ctl_d.bitn = ctl_q.bitn + 3'd1;
                    tx_adv     = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = ctl_q.fast ? LD_FAST_HALF : LD_SLOW_HALF;
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_WACK;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACK;
                end
            end
            ST_WACK: begin
                if (!lclk_s) begin
                    ctl_d.st = ST_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = LD_BUSY;
                end else if (tmr_zero) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.err = 1'b1;
                end
            end
            ST_BUSY: begin
                if (lclk_s) begin
                    ctl_d.st   = ST_GAP;
                    ctl_d.done = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = ctl_q.fast ? LD_GAP_FAST : LD_GAP_SLOW;
                end else if (tmr_zero) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.err = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_zero) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.fast <= 1'b0;
            ctl_q.bitn <= '0;
            ctl_q.done <= 1'b0;
            ctl_q.err  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // pad-side decode from the registered state
    always_comb begin
        lclk_oe_o = (ctl_q.st == ST_LOW) || (ctl_q.st == ST_HIGH) || (ctl_q.st == ST_HOLD);
        lclk_o    = (ctl_q.st != ST_LOW);
        dout_o    = lclk_oe_o ? tx_msb : 1'b1;
    end

    assign done_o = ctl_q.done;
    assign err_o  = ctl_q.err;

    // guards
    AST_START_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && start_i) |=> (lclk_oe_o && !lclk_o)); // R2
    AST_DOUT_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HIGH) |-> $stable(dout_o)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_ERR_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!done_o && ctl_q.st == ST_IDLE)); // R8
    AST_BUSY_ERR_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && $past(ctl_q.st) == ST_BUSY) |-> !$past(lclk_s)); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE && $past(ctl_q.st) != ST_IDLE) |-> $stable(ctl_q.fast)); // R10

endmodule

// File: tb/lensbus_host_test.sv
module lensbus_host_test;
    localparam int CLK_PERIOD_NS = 500;
    localparam longint unsigned CLK_HZ = 64'd2_000_000;
    localparam longint unsigned ACK_NS  = 64'd20_000;
    localparam longint unsigned BUSY_NS = 64'd200_000;
    localparam int SYNC = 2;

    function automatic int cyc(input longint unsigned ns);
        longint unsigned c;
        c = (ns * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 1 : int'(c);
    endfunction

    localparam int SH = 13, FH = 2, RL = 2, GS = 240, GF = 36, AT = 40, BT = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_mode = 1'b0, start = 1'b0, din = 1'b1, lens_pull = 1'b0;
    logic [7:0] tx_byte = '0;
    logic [7:0] rx_byte;
    logic done, err, lclk, lclk_oe, dout, bus_clk;
    int checks = 0, errors = 0;
    bit finished = 0;

    assign bus_clk = lclk_oe ? lclk : ~lens_pull;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    lensbus_host #(
        .CLK_HZ(CLK_HZ), .ACK_TMO_NS(ACK_NS), .BUSY_TMO_NS(BUSY_NS), .SYNC_STAGES(SYNC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .fast_mode_i(fast_mode), .start_i(start),
        .tx_byte_i(tx_byte), .rx_byte_o(rx_byte), .done_o(done), .err_o(err),
        .lclk_o(lclk), .lclk_oe_o(lclk_oe), .lclk_i(bus_clk), .dout_o(dout), .din_i(din)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind: 0 normal, 1 no acknowledge, 2 busy too long
    task automatic xfer(input logic [7:0] tx, input logic [7:0] lb, input logic fm,
                        input int ack_dly, input int busy_len, input int kind, input bit poke);
        int half, gapc, falls, rises, lowrun, highrun, bad_dout, bad_low, bad_high;
        int act_low, act_high, at, k;
        bit poked, early, first_low;
        logic prev, line;
        logic [7:0] lsh, rxv;
        half = fm ? FH : SH;
        gapc = fm ? GF : GS;
        falls = 0; rises = 0; lowrun = 0; highrun = 0;
        bad_dout = 0; bad_low = 0; bad_high = 0; act_low = 0; act_high = 0;
        poked = 0; early = 0; lsh = lb; prev = 1'b1; rxv = '0;
        @(negedge clk);
        fast_mode = fm; tx_byte = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_low = !bus_clk && lclk_oe;
        chk(first_low, "R7 start at earliest slot accepted", int'(bus_clk), 0);
        for (int c = 0; c < 600; c++) begin
            line = bus_clk;
            if (!lclk_oe) break;
            if (poke && falls == 3 && !poked) begin
                start = 1'b1; fast_mode = !fm; tx_byte = ~tx; poked = 1;
            end else begin
                start = 1'b0;
            end
            if (prev && !line) begin
                falls++;
                din = lsh[7];
                lsh = {lsh[6:0], 1'b0};
                if (falls > 1 && highrun != half) begin bad_high++; act_high = highrun; end
                highrun = 0;
            end
            if (!prev && line) begin
                rises++;
                if (lowrun != half) begin bad_low++; act_low = lowrun; end
                lowrun = 0;
            end
            if (!line) begin
                lowrun++;
                if (falls >= 1 && falls <= 8 && dout != tx[8-falls]) bad_dout++;
            end else begin
                highrun++;
            end
            prev = line;
            @(negedge clk);
        end
        start = 1'b0;
        chk(falls == 8, "R2 falling edge count", falls, 8);
        chk(rises == 8, "R2 rising edge count", rises, 8);
        chk(bad_dout == 0, poke ? "R10 dout unaffected by new inputs" : "R2 dout bit order", bad_dout, 0);
        chk(bad_low == 0, poke ? "R10 low phase unaffected" : "R4 low phase length", act_low, half);
        chk(bad_high == 0, poke ? "R10 high phase unaffected" : "R4 high phase length", act_high, half);
        chk(highrun == RL, "R5 hold after last rise", highrun, RL);
        chk(dout == 1'b1, "R5 data high after release", int'(dout), 1);

        if (kind == 1) begin
            at = -1; early = 0;
            for (k = 1; k <= AT + 5; k++) begin
                @(negedge clk);
                if (err && at < 0) at = k;
                if (done) early = 1;
            end
            chk(at == AT, "R8 acknowledge timeout cycle", at, AT);
            chk(!early && !lclk_oe, "R8 no done and idle after timeout", int'(early), 0);
            return;
        end

        for (k = 0; k < ack_dly; k++) begin
            @(negedge clk);
            if (lclk_oe || done || err) early = 1;
        end
        lens_pull = 1'b1;

        if (kind == 2) begin
            at = -1;
            for (k = 1; k <= BT + 6; k++) begin
                @(negedge clk);
                if (err && at < 0) at = k;
                if (done) early = 1;
            end
            lens_pull = 1'b0;
            chk(at == BT + 3, "R9 busy timeout cycle", at, BT + 3);
            chk(!early, "R9 no done on busy timeout", int'(early), 0);
            return;
        end

        for (k = 0; k < busy_len; k++) begin
            @(negedge clk);
            if (done || err || lclk_oe) early = 1;
        end
        chk(!early, "R6 no done or drive while lens holds line", int'(early), 0);
        lens_pull = 1'b0;
        at = -1;
        for (k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (done) begin at = k; rxv = rx_byte; break; end
        end
        chk(at == SYNC + 1, "R6 done delay after line release", at, SYNC + 1);
        chk(rxv == lb, "R3 received byte", int'(rxv), int'(lb));
        @(negedge clk);
        chk(!done && !err, "R6 done lasts one cycle", int'(done), 0);
        repeat (gapc - 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        chk(cyc(64'd6_500) == SH && cyc(64'd1_000) == FH && cyc(64'd1_000) == RL &&
            cyc(64'd120_000) == GS && cyc(64'd18_000) == GF && cyc(ACK_NS) == AT &&
            cyc(BUSY_NS) == BT, "R4 bench cycle table", SH, cyc(64'd6_500));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lclk_oe && dout && !done && !err, "R1 reset state",
            {28'd0, lclk_oe, dout, done, err}, 32'b0100);

        // every outgoing byte at the fast rate, varied lens timing
        for (int v = 0; v < 256; v++)
            xfer(8'(v), 8'(v * 7 + 13), 1'b1, v % 5, 1 + v % 4, 0, 1'b0);

        // slow rate patterns
        begin
            logic [7:0] pats [6];
            pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
            foreach (pats[i]) xfer(pats[i], ~pats[i], 1'b0, 2, 6, 0, 1'b0);
        end

        // early start during the gap is dropped
        start = 1'b1; tx_byte = 8'h3C;
        @(negedge clk);
        start = 1'b0;
        begin
            bit drove;
            drove = 0;
            for (int i = 0; i < 6; i++) begin
                if (lclk_oe || !bus_clk) drove = 1;
                @(negedge clk);
            end
            chk(!drove, "R7 early start ignored", int'(drove), 0);
        end

        // boundary acknowledge delay and longest busy
        xfer(8'hC3, 8'h96, 1'b1, AT - 3, 1, 0, 1'b0);
        xfer(8'h69, 8'h0F, 1'b1, 0, BT, 0, 1'b0);

        // inputs toggled mid-byte in both modes
        xfer(8'hB4, 8'h4B, 1'b0, 1, 3, 0, 1'b1);
        xfer(8'h2D, 8'hD2, 1'b1, 1, 3, 0, 1'b1);

        // timeouts, each followed by a normal byte
        xfer(8'h77, 8'h11, 1'b1, 0, 0, 1, 1'b0);
        repeat (4) @(negedge clk);
        xfer(8'h12, 8'h34, 1'b1, 1, 2, 0, 1'b0);
        xfer(8'h88, 8'h22, 1'b1, 1, 0, 2, 1'b0);
        repeat (4) @(negedge clk);
        xfer(8'h56, 8'h78, 1'b0, 1, 2, 0, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule